// File: doc/BRIEF.md
# Address-masked GPIO port controller

This block is a bus-attached controller for a small bank of general-purpose pins (eight by default). Each pin has a direction bit. An output pin drives the value held in an output latch, and an input pin is sampled through a two-stage synchroniser. Software reaches the pins through an APB-style slave port with two register windows. The first is a direction register. The second is a data window that covers a whole range of word addresses.

The data window does not need set or clear registers. Address bits [9:2] of each data access act as a per-pin mask. A read returns only the pins whose mask bit is 1 and returns 0 for every other pin. A write changes only the latch bits whose mask bit is 1. One bus write can therefore change a single pin, or any chosen group of pins, without a read-modify-write sequence, so concurrent software agents cannot race on a shared latch.

Top module: `gpio_mask_port`

## Requirements
- R1: A synchronous active-high reset clears the direction register to all inputs and the output latch to 0. After reset, `pin_oe` and `pin_out` both read 0.
- R2: `pin_oe` always equals the direction register and `pin_out` always equals the output latch. Both change on the clock edge that completes the write.
- R3: The direction register sits at byte offset 0x400 and holds one bit per pin. Bit n set to 1 makes pin n an output. A read returns the register in bits [7:0] with 0 above. Write data bits above bit 7 are dropped.
- R4: Any byte offset in 0x000 to 0x3FF selects the data window, with address bits [9:2] as the mask. A write loads data bit n into latch bit n only where mask bit n is 1. Every other latch bit keeps its value, and mask 0 changes nothing.
- R5: A data read returns, in bit n, the value of pin n where mask bit n is 1 and 0 where it is 0. Bits [31:8] read as 0.
- R6: In a data read, an output pin reports its latch value. An input pin reports `pin_in` after two synchroniser flops, so a pin change made in the same cycle as the setup phase is not yet visible.
- R7: Byte offset 1 << (n+2) accesses pin n alone. Writing 1 or 0 in bit n there sets or clears only that pin, and a read there returns only that pin.
- R8: An offset that is neither in the data window nor 0x400 reads as 0, and a write to it changes neither register.
- R9: `pready` is always 1, and every transfer takes exactly one setup cycle and one access cycle.
- R10: A write takes effect only in the access phase (`psel` and `penable` both high). A setup phase alone changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write transfer, 0 = read transfer |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Transfer ready, held at 1 |
| pin_in | input | 8 | Pin levels from the pads |
| pin_out | output | 8 | Output latch driven to the pads |
| pin_oe | output | 8 | Per-pin output enable |

## Verification
The bench writes with partial masks, such as two bits at once, a single pin, and the empty mask. A design that ignored the mask, or that treated it as a byte enable, would clear or set neighbouring pins. Reads run with the direction register split half and half, so that swapping the latch source and the pad source produces a wrong nibble. A read issued in the same cycle as a pin change shows whether the synchroniser has two stages: with fewer, the new level leaks through early. The bench also makes writes to 0x404, setup-only writes, and direction writes with upper data bits set. These expose sloppy decoding, because such a write would alter a register that should have stayed as it was.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_DATA = 2'd1,
    ACC_DIR  = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/gpio_apb_decode.sv
module gpio_apb_decode
  import gpio_mask_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int PINS    = 8,
  parameter int DIR_OFS = 'h400
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output acc_kind_e         kind,
  output logic [PINS-1:0]   mask,
  output logic              wr_stb,
  output logic              rd_setup
);
  localparam int MSK_LO = 2;
  localparam int MSK_HI = PINS + 1;
  localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(DIR_OFS);

  logic in_data_window;
  logic is_dir;

  always_comb begin
    in_data_window = (paddr[ADDR_W-1:MSK_HI+1] == '0);
    is_dir         = (paddr[ADDR_W-1:2] == DIR_ADDR[ADDR_W-1:2]);
    mask           = paddr[MSK_HI:MSK_LO];
    if (in_data_window)  kind = ACC_DATA;
    else if (is_dir)     kind = ACC_DIR;
    else                 kind = ACC_NONE;
    wr_stb   = psel && penable && pwrite;
    rd_setup = psel && !penable && !pwrite;
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int PINS   = 8,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] d_async,
  output logic [PINS-1:0] q_sync
);
  logic [PINS-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '0;
          else     stage_q[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_mask_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_stb,
  input  acc_kind_e       kind,
  input  logic [PINS-1:0] mask,
  input  logic [PINS-1:0] wdata,
  output logic [PINS-1:0] dir_q,
  output logic [PINS-1:0] out_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
    end else if (wr_stb && kind == ACC_DIR) begin
      dir_q <= wdata;
    end
  end

  generate
    for (genvar b = 0; b < PINS; b++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst) begin
          out_q[b] <= 1'b0;
        end else if (wr_stb && kind == ACC_DATA && mask[b]) begin
          out_q[b] <= wdata[b];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_mask_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int PINS        = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DIR_OFS     = 'h400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe
);
  localparam int PAD_W = DATA_W - PINS;

  acc_kind_e       kind;
  logic [PINS-1:0] mask;
  logic            wr_stb;
  logic            rd_setup;
  logic [PINS-1:0] dir_q;
  logic [PINS-1:0] out_q;
  logic [PINS-1:0] in_s;
  logic [PINS-1:0] rd_val;

  gpio_apb_decode #(
    .ADDR_W (ADDR_W),
    .PINS   (PINS),
    .DIR_OFS(DIR_OFS)
  ) u_dec (
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .kind    (kind),
    .mask    (mask),
    .wr_stb  (wr_stb),
    .rd_setup(rd_setup)
  );

  gpio_in_sync #(
    .PINS  (PINS),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d_async(pin_in),
    .q_sync (in_s)
  );

  gpio_port_regs #(
    .PINS(PINS)
  ) u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr_stb(wr_stb),
    .kind  (kind),
    .mask  (mask),
    .wdata (pwdata[PINS-1:0]),
    .dir_q (dir_q),
    .out_q (out_q)
  );

  // Read value selected per bit: latch for outputs, synchronised pad for inputs.
  always_comb begin
    unique case (kind)
      ACC_DATA: rd_val = ((dir_q & out_q) | (~dir_q & in_s)) & mask;
      ACC_DIR:  rd_val = dir_q;
      default:  rd_val = '0;
    endcase
  end

  // Read data is registered on the setup edge so it is stable through access.
  always_ff @(posedge clk) begin
    if (rst)           prdata <= '0;
    else if (rd_setup) prdata <= {{PAD_W{1'b0}}, rd_val};
  end

  assign pready  = 1'b1;
  assign pin_oe  = dir_q;
  assign pin_out = out_q;
endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int PINS    = 8,
  parameter int DIR_OFS = 'h400
) (
  input logic              clk,
  input logic              rst,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] prdata,
  input logic              pready,
  input logic [PINS-1:0]   pin_out,
  input logic [PINS-1:0]   pin_oe
);
  localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(DIR_OFS);

  logic data_hit, dir_hit, wr_acc, rd_set;
  assign data_hit = (paddr[ADDR_W-1:PINS+2] == '0);
  assign dir_hit  = (paddr[ADDR_W-1:2] == DIR_ADDR[ADDR_W-1:2]);
  assign wr_acc   = psel && penable && pwrite;
  assign rd_set   = psel && !penable && !pwrite;

  // R1: reset leaves all pins as inputs with a cleared latch
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (pin_oe == '0 && pin_out == '0));

  // R9: slave never stalls
  assert_pready_high_R9: assert property (@(posedge clk) disable iff (rst)
    pready == 1'b1);

  // R3, R8, R10: output enables move only on an access-phase write to the direction offset
  assert_oe_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !(wr_acc && dir_hit) |=> $stable(pin_oe));

  // R4, R10: latch holds when no data-window write completes
  assert_out_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !(wr_acc && data_hit) |=> $stable(pin_out));

  // R4: unmasked latch bits never change on a data write
  assert_out_mask_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && data_hit) |=>
      (((pin_out ^ $past(pin_out)) & ~$past(paddr[PINS+1:2])) == '0));

  // R5: masked-off bits and the upper word read zero
  assert_read_mask_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_set && data_hit) |=>
      ((prdata[PINS-1:0] & ~$past(paddr[PINS+1:2])) == '0 &&
       prdata[DATA_W-1:PINS] == '0));

  // R8: undecoded offsets read as zero
  assert_undecoded_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_set && !data_hit && !dir_hit) |=> (prdata == '0));
endmodule

bind gpio_mask_port gpio_mask_port_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .PINS   (PINS),
  .DIR_OFS(DIR_OFS)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .psel   (psel),
  .penable(penable),
  .pwrite (pwrite),
  .paddr  (paddr),
  .prdata (prdata),
  .pready (pready),
  .pin_out(pin_out),
  .pin_oe (pin_oe)
);

// File: tb/test_gpio_mask_port.sv
`timescale 1ns/1ps
module test_gpio_mask_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pin_out, pin_oe;

  int n_checks = 0;
  int n_fail   = 0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  gpio_mask_port i_gpio_mask_port (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
    step(); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    step(); penable = 1;
    step(); psel = 0; penable = 0; pwrite = 0;
  endtask

  // Driver: pushes the expected read value, then runs the transfer.
  task automatic apb_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    step(); psel = 1; pwrite = 0; penable = 0; paddr = a;
    step(); penable = 1;
    step(); psel = 0; penable = 0;
  endtask

  // Monitor: compares read data in the middle of each access phase.
  always @(negedge clk) begin
    if (psel && penable && !pwrite) begin
      if (exp_q.size() == 0) begin
        check("scoreboard underflow", 32'h1, 32'h0);
      end else begin
        check(tag_q.pop_front(), prdata, exp_q.pop_front());
      end
    end
  end

  task automatic pins(input string tag, input logic [7:0] oe, input logic [7:0] o);
    @(negedge clk);
    check({tag, " pin_oe"}, {24'h0, pin_oe}, {24'h0, oe});
    check({tag, " pin_out"}, {24'h0, pin_out}, {24'h0, o});
  endtask

  initial begin : watchdog
    #200000;
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (4) step();
    rst = 0;
    pins("R1 reset", 8'h00, 8'h00);
    check("R9 pready", {31'h0, pready}, 32'h1);
    apb_read(12'h400, 32'h0, "R1 dir after reset");
    apb_read(12'h3FC, 32'h0, "R1 data after reset");

    // Direction: upper data bits dropped
    apb_write(12'h400, 32'hFFFF_FF0F);
    pins("R2 R3 dir write", 8'h0F, 8'h00);
    apb_read(12'h400, 32'h0000_000F, "R3 dir readback");

    // Full-mask write
    apb_write(12'h3FC, 32'hFFFF_FFA5);
    pins("R2 R4 full mask", 8'h0F, 8'hA5);
    // Single pin clear of pin 2
    apb_write(12'h010, 32'h0);
    pins("R7 clear pin2", 8'h0F, 8'hA1);
    // Two-bit mask (pins 0,1) with data 0xFE
    apb_write(12'h00C, 32'hFE);
    pins("R4 two-bit mask", 8'h0F, 8'hA2);
    // Empty mask
    apb_write(12'h000, 32'hFF);
    pins("R4 empty mask", 8'h0F, 8'hA2);
    // Single pin set of pin 6
    apb_write(12'h100, 32'h40);
    pins("R7 set pin6", 8'h0F, 8'hE2);

    // Reads with mixed direction
    pin_in = 8'h3C;
    repeat (4) step();
    apb_read(12'h3FC, 32'h32, "R6 mixed read");
    apb_read(12'h3C0, 32'h30, "R5 upper mask");
    apb_read(12'h03C, 32'h02, "R5 lower mask");
    apb_read(12'h080, 32'h20, "R7 read pin5");
    apb_read(12'h004, 32'h00, "R7 read pin0");

    // Synchroniser delay: change in the same cycle as setup
    step(); pin_in = 8'hC3; psel = 1; pwrite = 0; penable = 0; paddr = 12'h3F0;
    exp_q.push_back(32'h30); tag_q.push_back("R6 sync delay");
    step(); penable = 1;
    step(); psel = 0; penable = 0;
    repeat (3) step();
    apb_read(12'h3F0, 32'hC0, "R6 sync settled");

    // Undecoded offsets
    apb_write(12'h404, 32'hFF);
    pins("R8 write 0x404", 8'h0F, 8'hE2);
    apb_write(12'h800, 32'h00);
    pins("R8 write 0x800", 8'h0F, 8'hE2);
    apb_read(12'h404, 32'h0, "R8 read 0x404");
    apb_read(12'hC00, 32'h0, "R8 read 0xC00");

    // Setup phase only
    step(); psel = 1; pwrite = 1; penable = 0; paddr = 12'h3FC; pwdata = 32'h0;
    step(); psel = 0; pwrite = 0;
    pins("R10 setup only", 8'h0F, 8'hE2);

    // All inputs again
    apb_write(12'h400, 32'h0);
    pins("R2 dir cleared", 8'h00, 8'hE2);
    apb_read(12'h3FC, 32'hC3, "R6 all inputs");
    check("R9 pready end", {31'h0, pready}, 32'h1);

    repeat (3) step();
    check("R9 scoreboard empty", exp_q.size(), 32'h0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule